// File: doc/BRIEF.md
# FP Register List Transfer Sequencer

This block moves a chosen group of eight 96-bit floating-point registers between its internal register file and memory. It handles one register at a time, and each register goes over as three 32-bit words. A one-cycle start pulse supplies four things:

- a 16-bit extension word, which carries the direction, the list source and a static list;
- a flag that selects predecrement addressing;
- a starting byte address;
- an 8-bit list value taken from an integer data register. The block names that register on `dreg_sel`.

The 8-bit list is always scanned from its most significant bit downward. The addressing mode decides both the order in which registers are visited and which register each list bit stands for. In predecrement mode the walk runs from register 7 down to register 0, and the address drops by 12 before each register. In post-increment mode the walk runs from register 0 up to register 7, and the address rises by 12 after each register.

The sequencer ends with a one-cycle `done` pulse. The updated address is valid with that pulse. If a memory access faults, the sequence stops at once and `fault` is raised together with `done`.

Top module: `fp_list_xfer`

## Requirements
- R1: After reset `done`, `fault` and `mem_req` are low and `final_addr` is zero.
- R2: Extension bit 13 set makes every access a write of register data to memory. Bit 13 clear makes every access a read into the registers.
- R3: With extension bit 11 set, the list is `dreg_val`, and `dreg_sel` equals extension bits 6:4. With bit 11 clear, the list is extension bits 7:0.
- R4: In predecrement mode list bit 7 selects register 7 and the walk runs 7 down to 0. In post-increment mode list bit 7 selects register 0 and the walk runs 0 up to 7.
- R5: A selected register is accessed as three words at base, base+4 and base+8, with bits 95:64 first. A request holds its address until ack or fault.
- R6: The base is the current address minus 12 in predecrement mode, and the current address in post-increment mode, which then rises by 12. On a clean end, `final_addr` equals start minus or plus 12 per selected register.
- R7: A register whose list bit is clear issues no memory request.
- R8: An empty list raises `done` within 9 cycles of the start edge with no memory request.
- R9: The first faulting access ends the sequence. No further request is issued, and `fault` and `done` pulse together. `final_addr` is the base of the faulting register.
- R10: Data is moved bit for bit. A register loaded and later stored returns the same words.
- R11: A start pulse while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| ext_word | input | 16 | Extension word: direction, list source, register number, static list |
| predec | input | 1 | 1 = predecrement addressing, 0 = post-increment |
| start_addr | input | AW | Starting byte address |
| dreg_sel | output | 3 | Number of the integer register supplying a dynamic list |
| dreg_val | input | 8 | Contents of the selected integer register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Access completed |
| mem_fault | input | 1 | Access failed |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fault | output | 1 | Sequence ended by a fault (with done) |
| final_addr | output | AW | Address after the sequence |

## Verification
The assertions assume three things about the memory side:
- `mem_ack` and `mem_fault` only answer an outstanding request;
- they arrive at most one at a time per access;
- start addresses are word aligned.

The bench memory model enforces these rules. It answers only while `mem_req` is high, drops its answer one cycle later, and raises a fault only at one chosen address. Every stimulus address is a multiple of four.

// File: rtl/fp_list_xfer.sv
module fp_list_xfer #(
  parameter int NREG = 8,
  parameter int WORD = 32,
  parameter int WPR  = 3,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [15:0]     ext_word,
  input  logic            predec,
  input  logic [AW-1:0]   start_addr,
  output logic [2:0]      dreg_sel,
  input  logic [NREG-1:0] dreg_val,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [WORD-1:0] mem_wdata,
  input  logic [WORD-1:0] mem_rdata,
  input  logic            mem_ack,
  input  logic            mem_fault,
  output logic            done,
  output logic            fault,
  output logic [AW-1:0]   final_addr
);
  localparam int IW   = $clog2(NREG);
  localparam int WSW  = $clog2(WPR);
  localparam int REGW = WORD * WPR;
  localparam int WB   = WORD / 8;
  localparam int STEP = WB * WPR;

  typedef enum logic [1:0] {IDLE, SCAN, XFER} st_t;
  st_t st;

  logic [REGW-1:0] rf [NREG];
  logic [NREG-1:0] mask_q;
  logic [IW-1:0]   idx, cnt;
  logic [WSW-1:0]  wsel;
  logic [AW-1:0]   addr_q;
  logic            pd_q, store_q, done_q, fault_q;
  logic            last;

  wire unused_ext = ^{ext_word[15:14], ext_word[12], ext_word[10:8]};

  assign dreg_sel   = ext_word[6:4];
  assign mem_req    = (st == XFER);
  assign mem_we     = store_q;
  assign mem_addr   = addr_q + AW'(wsel) * AW'(WB);
  assign mem_wdata  = rf[idx][(WPR-1-int'(wsel))*WORD +: WORD];
  assign done       = done_q;
  assign fault      = fault_q;
  assign final_addr = addr_q;
  assign last       = (cnt == IW'(NREG-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      mask_q  <= '0;
      idx     <= '0;
      cnt     <= '0;
      wsel    <= '0;
      addr_q  <= '0;
      pd_q    <= 1'b0;
      store_q <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (st)
        IDLE: if (start) begin
          mask_q  <= ext_word[11] ? dreg_val : ext_word[NREG-1:0];
          pd_q    <= predec;
          store_q <= ext_word[13];
          addr_q  <= start_addr;
          idx     <= predec ? IW'(NREG-1) : '0;
          cnt     <= '0;
          st      <= SCAN;
        end
        SCAN: begin
          if (mask_q[NREG-1]) begin
            if (pd_q) addr_q <= addr_q - AW'(STEP);
            wsel <= '0;
            st   <= XFER;
          end else begin
            mask_q <= mask_q << 1;
            if (last) begin
              done_q <= 1'b1;
              st     <= IDLE;
            end else begin
              cnt <= cnt + 1'b1;
              idx <= pd_q ? idx - 1'b1 : idx + 1'b1;
            end
          end
        end
        XFER: begin
          if (mem_fault) begin
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            st      <= IDLE;
          end else if (mem_ack) begin
            if (!store_q) rf[idx][(WPR-1-int'(wsel))*WORD +: WORD] <= mem_rdata;
            if (wsel == WSW'(WPR-1)) begin
              if (!pd_q) addr_q <= addr_q + AW'(STEP);
              mask_q <= mask_q << 1;
              if (last) begin
                done_q <= 1'b1;
                st     <= IDLE;
              end else begin
                cnt <= cnt + 1'b1;
                idx <= pd_q ? idx - 1'b1 : idx + 1'b1;
                st  <= SCAN;
              end
            end else begin
              wsel <= wsel + 1'b1;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fp_list_xfer_chk.sv
module fp_list_xfer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_fault,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          fault
);
  // R5
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_fault |=> mem_req && $stable(mem_addr));
  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  // R9
  stop_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_fault |=> !mem_req);
  // R9
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);
  // R8
  quiet_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind fp_list_xfer fp_list_xfer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_fault(mem_fault), .mem_addr(mem_addr), .done(done), .fault(fault)
);

// File: tb/tb_fp_list_xfer.sv
module tb_fp_list_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ext_word = '0;
  logic        predec = 1'b0;
  logic [31:0] start_addr = '0;
  logic [2:0]  dreg_sel;
  logic [7:0]  dreg_val;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_fault = 1'b0;
  logic        done, fault;
  logic [31:0] final_addr;

  always #5 clk = ~clk;

  fp_list_xfer dut (.*);

  logic [31:0] mem [256];
  logic [31:0] exp_mem [256];
  logic [95:0] sh [8];
  logic [7:0]  dregs [8];
  assign dreg_val = dregs[dreg_sel];

  int total = 0, bad = 0, acc = 0;
  logic        fa_en = 1'b0;
  logic [31:0] fa = '0;

  always @(negedge clk) begin
    if (!rst_n || mem_ack || mem_fault) begin
      mem_ack = 1'b0; mem_fault = 1'b0;
    end else if (mem_req) begin
      acc++;
      if (fa_en && mem_addr == fa) mem_fault = 1'b1;
      else begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[9:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] ext, input logic pd, input logic [31:0] a0,
                     input logic fen, input logic [31:0] faddr, input bit poke);
    logic [7:0] m;
    logic [31:0] a, base;
    bit efault, stop;
    int eacc, cyc, mism, r;
    m = ext[11] ? dregs[ext[6:4]] : ext[7:0];
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    a = a0; efault = 0; stop = 0; eacc = 0;
    for (int k = 0; k < 8 && !stop; k++) begin
      r = pd ? 7 - k : k;
      if (m[7-k]) begin
        base = pd ? a - 32'd12 : a;
        a = base;
        for (int w = 0; w < 3 && !stop; w++) begin
          eacc++;
          if (fen && base + 32'(4*w) == faddr) begin efault = 1; stop = 1; end
          else if (ext[13]) exp_mem[(base[9:2] + 8'(w))] = sh[r][(2-w)*32 +: 32];
          else sh[r][(2-w)*32 +: 32] = mem[(base[9:2] + 8'(w))];
        end
        if (!stop && !pd) a = base + 32'd12;
      end
    end
    @(negedge clk);
    fa_en = fen; fa = faddr; acc = 0;
    ext_word = ext; predec = pd; start_addr = a0; start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke && cyc == 3) begin
        start = 1'b1; ext_word = ~ext; predec = ~pd; start_addr = a0 + 32'h40;
      end
      if (poke && cyc == 4) begin
        ext_word = ext; predec = pd; start_addr = a0;
      end
    end while (!done && cyc < 5000);
    chk(done, "R9 done seen", 32'(done), 32'd1);
    chk(fault == efault, "R9 fault flag", 32'(fault), 32'(efault));
    chk(final_addr == a, "R6 final address", final_addr, a);
    chk(acc == eacc, "R7 access count", 32'(acc), 32'(eacc));
    if (eacc == 0) chk(cyc <= 9, "R8 empty list latency", 32'(cyc), 32'd9);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, poke ? "R11 memory image" : "R2 R4 R5 memory image", 32'(mism), 32'd0);
    @(negedge clk);
    chk(!mem_req, "R9 no request after end", 32'(mem_req), 32'd0);
    fa_en = 1'b0;
  endtask

  localparam int NV = 8;
  localparam logic [15:0] V_EXT [NV] = '{16'h10FF, 16'h20FF, 16'h2081, 16'h2081,
                                         16'h0850, 16'h000C, 16'h20FF, 16'h2000};
  localparam logic        V_PD  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] V_ADR [NV] = '{32'h100, 32'h300, 32'h200, 32'h380,
                                         32'h040, 32'h0A0, 32'h280, 32'h1F0};

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A, 8'hC3};
    for (int r = 0; r < 8; r++) sh[r] = '0;
    for (int r = 0; r < 8; r++) dregs[r] = 8'hFF;
    dregs[5] = 8'h24;
    dregs[3] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !fault, "R1 done/fault low", {30'd0, done, fault}, 32'd0);
    chk(!mem_req, "R1 no request", 32'(mem_req), 32'd0);
    chk(final_addr == 32'd0, "R1 address zero", final_addr, 32'd0);
    rst_n = 1'b1;
    // table of vectors: R2 R4 R5 R6 R3 R10
    for (int v = 0; v < NV; v++) run(V_EXT[v], V_PD[v], V_ADR[v], 1'b0, 32'd0, 1'b0);
    ext_word = 16'h0850;
    #1;
    // R3 register select
    chk(dreg_sel == 3'd5, "R3 dreg_sel", 32'(dreg_sel), 32'd5);
    // R3 dynamic empty list overriding nonzero static bits
    run(16'h28B3, 1'b1, 32'h1C0, 1'b0, 32'd0, 1'b0);
    // R9 store fault at register 1 word 1, post-increment
    run(16'h20F0, 1'b0, 32'h3C0, 1'b1, 32'h3D0, 1'b0);
    // R9 load fault at register 6 word 2, predecrement
    run(16'h00FF, 1'b1, 32'h180, 1'b1, 32'h170, 1'b0);
    // R10 dump all registers for bit-exact comparison
    run(16'h20FF, 1'b0, 32'h300, 1'b0, 32'd0, 1'b0);
    // R11 start during a running sequence
    run(16'h2081, 1'b1, 32'h3F0, 1'b0, 32'd0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule